// File: doc/BRIEF.md
# Counting register-lock scoreboard

This block guards register reads in a five-stage in-order pipeline (Fetch, Operand, ALU, Memory, Result). Every architectural register has a small up/down counter that holds the number of writes still in flight toward it. An instruction claims its destination while it sits in the Operand stage and gives it back when it reaches the Result stage. A counter is used instead of a single busy bit. When two writers of the same register are in the pipe together, the first write to retire does not free the register while the second is still outstanding.

The Operand-stage port carries two source register numbers, a destination number and a flag that says whether a destination is written. The block answers with a combinational stall. A stalled instruction holds in Operand, and the pipeline puts bubbles behind it. The Result-stage port reports each retiring destination. Register 0 is never locked. Reading it never stalls.

Top module: `lock_scoreboard`

## Requirements
- R1: Reset brings every counter to zero, so right after reset no source register number from 1 to 31 causes a stall.
- R2: While `iss_valid` is 1, `stall` is 1 in the same cycle if either nonzero source number names a register whose counter is nonzero. Otherwise `stall` is 0. When `iss_valid` is 0, `stall` is 0.
- R3: A claim happens at a rising clock edge where `iss_valid`=1, `stall`=0, `iss_dst_en`=1 and `iss_dst`≠0. It adds one to that register's counter, and the result can be seen on `stall` in the following cycle.
- R4: An instruction that stalls does not claim its destination. If the instruction is withdrawn after stalling, its destination stays unlocked.
- R5: At a rising edge where `ret_valid`=1 and `ret_dst`≠0, the counter of `ret_dst` goes down by one. A reader stops stalling in the cycle after the edge that brings the counter to zero. There is no same-cycle bypass.
- R6: After two back-to-back claims of one register, a reader of that register keeps stalling after the first release and only proceeds after the second.
- R7: A claim and a release of the same register at the same edge leave its counter unchanged.
- R8: Register 0 is never locked and a source number of 0 never stalls. A destination with `iss_dst_en`=0 changes no counter.
- R9: Counters track every value from 0 to 7 without wrapping. Seven claims need seven releases before the register is free. A release of a zero counter, or an eighth claim, is illegal use and is flagged as an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction occupies the Operand stage |
| iss_src_a | input | 5 | First source register number (0 = none) |
| iss_src_b | input | 5 | Second source register number (0 = none) |
| iss_dst_en | input | 1 | The Operand-stage instruction writes a destination |
| iss_dst | input | 5 | Destination register number |
| ret_valid | input | 1 | An instruction retires from the Result stage |
| ret_dst | input | 5 | Destination released by the retiring instruction |
| stall | output | 1 | Hold the Operand-stage instruction this cycle |

## Verification
`stall` is combinational from the current inputs and the stored counters, so it is due in the same cycle as the inputs. A claim or release reaches `stall` one edge later. The bench changes inputs on the falling edge and samples `stall` 1 ns afterwards. Each stimulus row therefore shows the counter state left by the previous rows' edges. The expected values assume exactly one counter update per rising edge. Multi-writer, same-cycle and seven-deep cases are then counted out edge by edge.

// File: rtl/lock_scoreboard.sv
module lock_scoreboard #(
  parameter int NREG = 32,
  parameter int CW   = 3,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [AW-1:0] iss_src_a,
  input  logic [AW-1:0] iss_src_b,
  input  logic          iss_dst_en,
  input  logic [AW-1:0] iss_dst,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_dst,
  output logic          stall
);
  logic [NREG-1:0][CW-1:0] cnt_q;
  logic busy_a, busy_b, claim, drop;

  assign busy_a = (iss_src_a != '0) && (cnt_q[iss_src_a] != '0);
  assign busy_b = (iss_src_b != '0) && (cnt_q[iss_src_b] != '0);
  assign stall  = iss_valid && (busy_a || busy_b);
  assign claim  = iss_valid && !stall && iss_dst_en && (iss_dst != '0);
  assign drop   = ret_valid && (ret_dst != '0);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign cnt_q[i] = '0;
    end else begin : g_cnt
      logic [CW-1:0] cnt_r;
      logic up, dn;
      assign up = claim && (iss_dst == AW'(i));
      assign dn = drop && (ret_dst == AW'(i));
      always_ff @(posedge clk) begin
        if (!rst_n)         cnt_r <= '0;
        else if (up && !dn) cnt_r <= cnt_r + 1'b1;
        else if (dn && !up) cnt_r <= cnt_r - 1'b1;
      end
      assign cnt_q[i] = cnt_r;
    end
  end
endmodule

// File: rtl/lock_scoreboard_chk.sv
module lock_scoreboard_chk #(
  parameter int NREG = 32,
  parameter int CW   = 3,
  localparam int AW  = $clog2(NREG)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    iss_valid,
  input logic [AW-1:0]           iss_src_a,
  input logic [AW-1:0]           iss_src_b,
  input logic                    iss_dst_en,
  input logic [AW-1:0]           iss_dst,
  input logic                    ret_valid,
  input logic [AW-1:0]           ret_dst,
  input logic                    stall,
  input logic [NREG-1:0][CW-1:0] cnt_q
);
  logic claim, drop, same;
  assign claim = iss_valid && !stall && iss_dst_en && (iss_dst != '0);
  assign drop  = ret_valid && (ret_dst != '0);
  assign same  = claim && drop && (iss_dst == ret_dst);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !same) |-> (cnt_q[ret_dst] != '0)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !same) |-> (cnt_q[iss_dst] != '1)); // R9
  AST_CLAIM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !same && !(drop && ret_dst == iss_dst)) |=>
      (cnt_q[$past(iss_dst)] == $past(cnt_q[iss_dst]) + 1'b1)); // R3
  AST_SAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    same |=> (cnt_q[$past(iss_dst)] == $past(cnt_q[iss_dst]))); // R7
  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_src_a != '0 && cnt_q[iss_src_a] != '0) |-> stall); // R2
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> !stall); // R2
endmodule

bind lock_scoreboard lock_scoreboard_chk #(.NREG(NREG), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_src_a(iss_src_a),
  .iss_src_b(iss_src_b), .iss_dst_en(iss_dst_en), .iss_dst(iss_dst),
  .ret_valid(ret_valid), .ret_dst(ret_dst), .stall(stall), .cnt_q(cnt_q));

// File: tb/lock_scoreboard_tb_top.sv
module lock_scoreboard_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_valid = 1'b0, iss_dst_en = 1'b0, ret_valid = 1'b0;
  logic [4:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0, ret_dst = '0;
  logic stall;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lock_scoreboard dut_i (.clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst_en(iss_dst_en),
    .iss_dst(iss_dst), .ret_valid(ret_valid), .ret_dst(ret_dst), .stall(stall));

  // {valid, src_a, src_b, dst_en, dst, ret_valid, ret_dst, exp_stall}
  localparam int NV = 9;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 5'd0, 5'd0, 1'b1, 5'd1, 1'b0, 5'd0, 1'b0},
    {1'b1, 5'd0, 5'd0, 1'b1, 5'd1, 1'b0, 5'd0, 1'b0},
    {1'b1, 5'd1, 5'd0, 1'b1, 5'd2, 1'b0, 5'd0, 1'b1},
    {1'b1, 5'd1, 5'd0, 1'b1, 5'd2, 1'b1, 5'd1, 1'b1},
    {1'b1, 5'd1, 5'd0, 1'b1, 5'd2, 1'b1, 5'd1, 1'b1},
    {1'b1, 5'd1, 5'd0, 1'b1, 5'd2, 1'b0, 5'd0, 1'b0},
    {1'b1, 5'd0, 5'd2, 1'b0, 5'd0, 1'b1, 5'd2, 1'b1},
    {1'b1, 5'd0, 5'd2, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0},
    {1'b1, 5'd1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0}
  };

  task automatic cyc(input logic v, input logic [4:0] sa, input logic [4:0] sb,
                     input logic de, input logic [4:0] d, input logic rv,
                     input logic [4:0] rd, input logic exp, input string req);
    @(negedge clk);
    iss_valid = v; iss_src_a = sa; iss_src_b = sb; iss_dst_en = de;
    iss_dst = d; ret_valid = rv; ret_dst = rd;
    #1;
    n_chk++;
    if (stall !== exp) begin
      n_err++;
      $display("FAIL %s: stall=%0b expected %0b", req, stall, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: all counters clear after reset
    for (int i = 1; i < 32; i++) cyc(1, 5'(i), 0, 0, 0, 0, 0, 1'b0, "R1 reset clear");
    // table: double writer then dependent readers (R2 R3 R5 R6)
    for (int k = 0; k < NV; k++) begin
      logic [23:0] w;
      w = VEC[k];
      cyc(w[23], w[22:18], w[17:13], w[12], w[11:7], w[6], w[5:1], w[0],
          "R6 table row (R2/R3/R5)");
    end
    // R2: stall only with a valid instruction
    cyc(1, 0, 0, 1, 5'd8, 0, 0, 1'b0, "R3 claim r8");
    cyc(0, 5'd8, 0, 0, 0, 0, 0, 1'b0, "R2 no stall when idle");
    cyc(1, 0, 5'd8, 0, 0, 1, 5'd8, 1'b1, "R2 src_b busy");
    cyc(1, 0, 5'd8, 0, 0, 0, 0, 1'b0, "R5 released next cycle");
    // R4: stalled instruction does not claim its destination
    cyc(1, 0, 0, 1, 5'd3, 0, 0, 1'b0, "R4 claim r3");
    for (int i = 0; i < 3; i++) cyc(1, 5'd3, 0, 1, 5'd5, 0, 0, 1'b1, "R4 held");
    cyc(0, 0, 0, 0, 0, 1, 5'd3, 1'b0, "R4 withdraw");
    cyc(1, 5'd5, 0, 0, 0, 0, 0, 1'b0, "R4 dst unclaimed");
    cyc(1, 5'd3, 0, 0, 0, 0, 0, 1'b0, "R4 r3 free");
    // R7: same-cycle claim and release
    cyc(1, 0, 0, 1, 5'd9, 0, 0, 1'b0, "R7 claim r9");
    cyc(1, 0, 0, 1, 5'd9, 1, 5'd9, 1'b0, "R7 claim+release");
    cyc(1, 5'd9, 0, 0, 0, 1, 5'd9, 1'b1, "R7 count unchanged");
    cyc(1, 5'd9, 0, 0, 0, 0, 0, 1'b0, "R7 free");
    // R8: register 0 and disabled destination
    cyc(1, 0, 0, 1, 5'd0, 0, 0, 1'b0, "R8 dst r0");
    cyc(1, 0, 0, 0, 5'd4, 1, 5'd0, 1'b0, "R8 dst disabled");
    cyc(1, 5'd4, 0, 0, 0, 0, 0, 1'b0, "R8 r4 not locked");
    cyc(1, 5'd0, 5'd0, 0, 0, 0, 0, 1'b0, "R8 r0 read");
    // R9: seven outstanding claims
    for (int i = 0; i < 7; i++) cyc(1, 0, 0, 1, 5'd6, 0, 0, 1'b0, "R9 claim r6");
    for (int i = 0; i < 7; i++) cyc(1, 5'd6, 0, 0, 0, 1, 5'd6, 1'b1, "R9 still locked");
    cyc(1, 5'd6, 0, 0, 0, 0, 0, 1'b0, "R9 free after seven");
    // R1: reset in the middle clears a lock
    cyc(1, 0, 0, 1, 5'd7, 0, 0, 1'b0, "R1 claim r7");
    cyc(1, 5'd7, 0, 0, 0, 0, 0, 1'b1, "R1 r7 locked");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cyc(1, 5'd7, 0, 0, 0, 0, 0, 1'b0, "R1 reset cleared r7");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: stall=%0b expected completion", stall);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule